// File: doc/BRIEF.md
# External interrupt sense controller

This block turns the levels and transitions on a small set of external interrupt lines into interrupt requests for a processor core. Each line has a two-bit sense field in an eight-bit control register. The field selects one of four detection modes: the line held low, any change of the line, a falling transition, or a rising transition. In the transition modes a detected event sets a pending flag. The flag holds until the core acknowledges the interrupt or software writes a one to clear it. In low-level mode there is no flag, and the request follows the line directly. A request reaches the core only when the global interrupt enable and the mask bit of that line are both set.

The block has two clocks. The I/O clock (`clk`) runs the synchronisers, the edge detectors and the control register. `io_run` marks the cycles in which the I/O clock counts as running, and transition detection happens only in those cycles. A second, slow clock (`wdt_clk`) drives a wake qualifier that works during power-down. The qualifier watches the lines that are armed for low-level detection. When the low level is seen on two consecutive slow-clock samples, it starts a start-up timer. When the timer expires it raises `wake`. At that same moment it raises `wake_irq` for each line that is still low, so a level that vanished during start-up wakes the device but delivers no interrupt.

Top module: `eint_sense_ctrl`

## Requirements
- R1: The control register resets to 0. A write stores the sense field of line 1 in bits 3:2 and of line 0 in bits 1:0, and `ctrl_q` returns those bits with bits 7:4 read as 0.
- R2: Sense field code 00 selects low level, 01 any change, 10 falling transition and 11 rising transition.
- R3: `irq_req[i]` can be 1 only while `gie` and `line_mask[i]` are both 1. The pending flag is set regardless of these two inputs.
- R4: In low-level mode, outside power-down, `irq_req[i]` rises two `clk` edges after the line falls and drops two edges after it rises. `pend[i]` stays 0 in this mode.
- R5: In a transition mode, a matching change on the line sets `pend[i]` at the third `clk` edge after the change. A low or high pulse that lasts one full `clk` period is caught.
- R6: `ack[i]` or `flag_w1c[i]` clears `pend[i]` at the next `clk` edge. A new event in the same cycle takes precedence over the clear.
- R7: While `io_run` is 0, no transition event is detected and the last compared line value is held. A change that happened during that time is detected on the first cycle that `io_run` is 1 again. The low-level request keeps following the line throughout.
- R8: While `powerdown` is 1, low-level requests are suppressed on `irq_req`. A line is armed for wake-up when `gie`, its mask bit and low-level mode are all set and its line is low in the `wdt_clk` domain.
- R9: With start-up count N, `wake` rises at the (5+N)-th `wdt_clk` edge after an armed line falls and stays low. It remains 1 until `powerdown` is seen at 0.
- R10: `wake_irq[i]` is set together with `wake` only if line i is still armed at the end of start-up. Otherwise the device wakes with `wake_irq` at 0. `wake_irq` is never 1 without `wake`.
- R11: A low level seen on only one `wdt_clk` sample, or a low level on a line that is not armed, does not start a wake-up.
- R12: During reset, `pend`, `irq_req`, `wake`, `wake_irq` and `ctrl_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| wdt_clk | input | 1 | Slow clock for the power-down wake qualifier |
| rst_n | input | 1 | Asynchronous reset, active low, for both domains |
| io_run | input | 1 | I/O clock running; enables transition detection |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_q | output | 8 | Control register read value |
| gie | input | 1 | Global interrupt enable |
| line_mask | input | NUM_LINES | Per-line interrupt mask |
| pin | input | NUM_LINES | External interrupt lines (asynchronous) |
| ack | input | NUM_LINES | Interrupt acknowledge, clears pending flag |
| flag_w1c | input | NUM_LINES | Write-one-to-clear strobe for pending flags |
| powerdown | input | 1 | Device is in power-down; held stable relative to `wdt_clk` |
| startup_cycles | input | CNT_W | Start-up time in `wdt_clk` cycles |
| pend | output | NUM_LINES | Pending flags of the transition modes |
| irq_req | output | NUM_LINES | Interrupt requests to the core |
| wake | output | 1 | Wake request (wdt_clk domain) |
| wake_irq | output | NUM_LINES | Lines that still hold their level at the end of start-up (wdt_clk domain) |

## Verification
The assertions check on every cycle that an edge event is always followed by a set pending flag, that a clear without a competing event empties it, and that low-level mode never leaves a flag. They also check that a frozen I/O clock never raises a new flag, that no request passes a cleared global enable or a power-down level path, and that wake stays up through power-down and only ever follows the start-up state. Only the bench can show the exact latencies: the three-edge flag latency, the (5+N)-edge wake-up, and the one-period pulse capture. It also shows the full four-mode by transition table on both lines, the vanished-level wake without an interrupt, and the rejection of a single slow-clock sample.

// File: rtl/eint_pkg.sv
package eint_pkg;

  localparam int CTRL_W  = 8;
  localparam int FIELD_W = 2;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ONE   = 2'd1,
    WK_START = 2'd2,
    WK_AWAKE = 2'd3
  } wake_st_e;

  // transition match for a sense mode; level mode never matches
  function automatic logic edge_hit(input sense_e mode, input logic prev, input logic cur);
    case (mode)
      SENSE_ANY:  return prev ^ cur;
      SENSE_FALL: return prev & ~cur;
      SENSE_RISE: return ~prev & cur;
      default:    return 1'b0;
    endcase
  endfunction

  // sense field of line idx inside the control register
  function automatic sense_e field_of(input logic [CTRL_W-1:0] r, input int idx);
    return sense_e'(r[idx*FIELD_W +: FIELD_W]);
  endfunction

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/eint_line.sv
module eint_line
  import eint_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   io_run,
  input  sense_e mode,
  input  logic   pin_s,
  input  logic   clr,
  output logic   edge_evt,
  output logic   pend
);
  logic prev;

  assign edge_evt = io_run & edge_hit(mode, prev, pin_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b1;
    end else if (io_run) begin
      prev <= pin_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (mode == SENSE_LOW) begin
      pend <= 1'b0;
    end else if (edge_evt) begin
      pend <= 1'b1;
    end else if (clr) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/eint_wake_qual.sv
module eint_wake_qual
  import eint_pkg::*;
#(
  parameter int NUM_LINES = 2,
  parameter int CNT_W     = 16
) (
  input  logic                 wdt_clk,
  input  logic                 rst_n,
  input  logic                 powerdown,
  input  logic [NUM_LINES-1:0] armed,
  input  logic [CNT_W-1:0]     startup_cycles,
  output logic                 wake,
  output logic [NUM_LINES-1:0] wake_irq,
  output wake_st_e             state
);
  logic [CNT_W-1:0] timer;
  logic             any_low;

  assign any_low = |armed;
  assign wake    = (state == WK_AWAKE);

  always_ff @(posedge wdt_clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= WK_IDLE;
      timer    <= '0;
      wake_irq <= '0;
    end else begin
      case (state)
        WK_IDLE: begin
          wake_irq <= '0;
          if (powerdown && any_low) state <= WK_ONE;
        end
        WK_ONE: begin
          if (powerdown && any_low) begin
            state <= WK_START;
            timer <= startup_cycles;
          end else begin
            state <= WK_IDLE;
          end
        end
        WK_START: begin
          if (!powerdown) begin
            state <= WK_IDLE;
          end else if (timer == '0) begin
            state    <= WK_AWAKE;
            wake_irq <= armed;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: begin
          if (!powerdown) begin
            state    <= WK_IDLE;
            wake_irq <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/eint_sense_ctrl.sv
module eint_sense_ctrl
  import eint_pkg::*;
#(
  parameter int NUM_LINES = 2,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 wdt_clk,
  input  logic                 rst_n,
  input  logic                 io_run,
  input  logic                 ctrl_wr,
  input  logic [CTRL_W-1:0]    ctrl_wdata,
  output logic [CTRL_W-1:0]    ctrl_q,
  input  logic                 gie,
  input  logic [NUM_LINES-1:0] line_mask,
  input  logic [NUM_LINES-1:0] pin,
  input  logic [NUM_LINES-1:0] ack,
  input  logic [NUM_LINES-1:0] flag_w1c,
  input  logic                 powerdown,
  input  logic [CNT_W-1:0]     startup_cycles,
  output logic [NUM_LINES-1:0] pend,
  output logic [NUM_LINES-1:0] irq_req,
  output logic                 wake,
  output logic [NUM_LINES-1:0] wake_irq
);
  localparam int USED_W = NUM_LINES * FIELD_W;

  logic [USED_W-1:0]    ctrl_reg;
  logic [NUM_LINES-1:0] pin_io;
  logic [NUM_LINES-1:0] pin_w;
  logic [NUM_LINES-1:0] edge_evt;
  logic [NUM_LINES-1:0] armed_w;
  logic [NUM_LINES-1:0] level_req;
  sense_e               mode_s [NUM_LINES];
  wake_st_e             wk_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_reg <= '0;
    else if (ctrl_wr) ctrl_reg <= ctrl_wdata[USED_W-1:0];
  end

  if (USED_W < CTRL_W) begin : g_pad
    logic unused_hi;
    assign unused_hi = ^ctrl_wdata[CTRL_W-1:USED_W];
    assign ctrl_q    = {{(CTRL_W-USED_W){1'b0}}, ctrl_reg};
  end else begin : g_full
    assign ctrl_q = ctrl_reg;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign mode_s[g] = field_of(ctrl_q, g);

    eint_sync #(.RST_VAL(1'b1)) u_sync_io (
      .clk(clk), .rst_n(rst_n), .d(pin[g]), .q(pin_io[g])
    );

    eint_sync #(.RST_VAL(1'b1)) u_sync_wdt (
      .clk(wdt_clk), .rst_n(rst_n), .d(pin[g]), .q(pin_w[g])
    );

    eint_line u_line (
      .clk(clk), .rst_n(rst_n), .io_run(io_run), .mode(mode_s[g]),
      .pin_s(pin_io[g]), .clr(ack[g] | flag_w1c[g]),
      .edge_evt(edge_evt[g]), .pend(pend[g])
    );

    assign level_req[g] = ~pin_io[g] & ~powerdown;
    assign armed_w[g]   = gie & line_mask[g] & (mode_s[g] == SENSE_LOW) & ~pin_w[g];
    assign irq_req[g]   = gie & line_mask[g] &
                          ((mode_s[g] == SENSE_LOW) ? level_req[g] : pend[g]);
  end

  eint_wake_qual #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W)) u_wake (
    .wdt_clk(wdt_clk), .rst_n(rst_n), .powerdown(powerdown), .armed(armed_w),
    .startup_cycles(startup_cycles), .wake(wake), .wake_irq(wake_irq),
    .state(wk_state)
  );
endmodule

// File: rtl/eint_sense_ctrl_chk.sv
module eint_sense_ctrl_chk
  import eint_pkg::*;
#(
  parameter int NUM_LINES = 2
) (
  input logic                 clk,
  input logic                 wdt_clk,
  input logic                 rst_n,
  input logic                 io_run,
  input logic                 gie,
  input logic                 powerdown,
  input logic [CTRL_W-1:0]    ctrl_q,
  input logic [NUM_LINES-1:0] ack,
  input logic [NUM_LINES-1:0] flag_w1c,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] irq_req,
  input logic [NUM_LINES-1:0] edge_evt,
  input logic                 wake,
  input logic [NUM_LINES-1:0] wake_irq,
  input wake_st_e             wk_state
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    a_r5_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[g] |=> pend[g]);

    a_r6_clear_empties_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ((ack[g] || flag_w1c[g]) && !edge_evt[g]) |=> !pend[g]);

    a_r4_level_mode_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[g*FIELD_W +: FIELD_W] == 2'b00) |=> !pend[g]);

    a_r7_frozen_no_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_run && !pend[g]) |=> !pend[g]);

    a_r3_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !irq_req[g]);

    a_r8_powerdown_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (powerdown && ctrl_q[g*FIELD_W +: FIELD_W] == 2'b00) |-> !irq_req[g]);
  end

  a_r9_wake_held: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    (wake && powerdown) |=> wake);

  a_r9_wake_after_startup: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    $rose(wake) |-> ($past(wk_state) == WK_START));

  a_r10_irq_needs_wake: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    (wake_irq != '0) |-> wake);
endmodule

bind eint_sense_ctrl eint_sense_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .wdt_clk(wdt_clk), .rst_n(rst_n), .io_run(io_run), .gie(gie),
  .powerdown(powerdown), .ctrl_q(ctrl_q), .ack(ack), .flag_w1c(flag_w1c),
  .pend(pend), .irq_req(irq_req), .edge_evt(edge_evt), .wake(wake),
  .wake_irq(wake_irq), .wk_state(wk_state)
);

// File: tb/test_eint_sense_ctrl.sv
module test_eint_sense_ctrl;
  localparam int NL = 2;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          wdt_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          io_run = 1'b1;
  logic          ctrl_wr = 1'b0;
  logic [7:0]    ctrl_wdata = '0;
  logic [7:0]    ctrl_q;
  logic          gie = 1'b0;
  logic [NL-1:0] line_mask = '0;
  logic [NL-1:0] pin = '1;
  logic [NL-1:0] ack = '0;
  logic [NL-1:0] flag_w1c = '0;
  logic          powerdown = 1'b0;
  logic [CW-1:0] startup_cycles = '0;
  logic [NL-1:0] pend;
  logic [NL-1:0] irq_req;
  logic          wake;
  logic [NL-1:0] wake_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always #20 wdt_clk = ~wdt_clk;

  eint_sense_ctrl #(.NUM_LINES(NL), .CNT_W(CW)) i_eint_sense_ctrl (
    .clk(clk), .wdt_clk(wdt_clk), .rst_n(rst_n), .io_run(io_run),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q), .gie(gie),
    .line_mask(line_mask), .pin(pin), .ack(ack), .flag_w1c(flag_w1c),
    .powerdown(powerdown), .startup_cycles(startup_cycles), .pend(pend),
    .irq_req(irq_req), .wake(wake), .wake_irq(wake_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected transition match, written from the encoding table
  function automatic bit exp_hit(input int md, input bit pv, input bit cv);
    if (md == 1) return pv != cv;
    if (md == 2) return pv == 1'b1 && cv == 1'b0;
    if (md == 3) return pv == 1'b0 && cv == 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v; step(1); ctrl_wr = 1'b0;
  endtask

  task automatic clr_all();
    flag_w1c = '1; step(1); flag_w1c = '0;
  endtask

  task automatic wake_run(input int rel_k, output int k_out, output int wi);
    k_out = 0; wi = 0;
    @(negedge wdt_clk); pin[0] = 1'b0;
    for (int k = 1; k <= 30; k++) begin
      @(posedge wdt_clk); #1;
      if (wake) begin k_out = k; wi = int'(wake_irq); break; end
      if (k == rel_k) begin @(negedge wdt_clk); pin[0] = 1'b1; end
    end
  endtask

  task automatic sleep_exit();
    @(negedge wdt_clk); powerdown = 1'b0; pin = '1;
    repeat (3) @(posedge wdt_clk);
    step(1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int k, wi;
    step(3);
    check("R12 pend in reset", int'(pend), 0);
    check("R12 irq_req in reset", int'(irq_req), 0);
    check("R12 wake in reset", int'(wake), 0);
    check("R12 wake_irq in reset", int'(wake_irq), 0);
    check("R12 ctrl_q in reset", int'(ctrl_q), 0);
    rst_n = 1'b1;
    step(2);

    // R1 field placement and read-as-zero upper bits
    wr_ctrl(8'hFF); check("R1 ctrl_q after FF", int'(ctrl_q), 8'h0F);
    wr_ctrl(8'hA6); check("R1 ctrl_q after A6", int'(ctrl_q), 8'h06);
    wr_ctrl(8'h00);

    // R2/R4/R5 sweep: every line, mode and transition pair
    gie = 1'b1; line_mask = '1;
    for (int ln = 0; ln < NL; ln++) begin
      for (int md = 0; md < 4; md++) begin
        for (int pv = 0; pv < 2; pv++) begin
          for (int cv = 0; cv < 2; cv++) begin
            bit ep;
            pin = '1;
            wr_ctrl(8'(md << (2 * ln)));
            pin[ln] = pv[0];
            step(4); clr_all(); step(1);
            pin[ln] = cv[0];
            step(3);
            ep = exp_hit(md, pv[0], cv[0]);
            check($sformatf("R2 R5 pend line%0d mode%0d %0d->%0d", ln, md, pv, cv),
                  int'(pend[ln]), int'(ep));
            check($sformatf("R2 R4 irq line%0d mode%0d %0d->%0d", ln, md, pv, cv),
                  int'(irq_req[ln]), (md == 0) ? int'(cv == 0) : int'(ep));
          end
        end
      end
    end

    // R4 level latency
    pin = '1; wr_ctrl(8'h00); step(4);
    pin[0] = 1'b0; step(1); check("R4 irq one edge after fall", int'(irq_req[0]), 0);
    step(1); check("R4 irq two edges after fall", int'(irq_req[0]), 1);
    pin[0] = 1'b1; step(2); check("R4 irq two edges after rise", int'(irq_req[0]), 0);

    // R5 one-period pulses
    wr_ctrl(8'h02); step(4); clr_all();
    pin[0] = 1'b0; step(1); pin[0] = 1'b1; step(3);
    check("R5 fall pulse one period", int'(pend[0]), 1);
    wr_ctrl(8'h03); step(4); clr_all();
    pin[0] = 1'b0; step(1); pin[0] = 1'b1; step(1);
    check("R5 rise not yet", int'(pend[0]), 0);
    step(2);
    check("R5 rise after low pulse", int'(pend[0]), 1);

    // R3 gating
    wr_ctrl(8'h02); step(4); clr_all();
    gie = 1'b0; line_mask = 2'b11;
    pin[0] = 1'b0; step(3);
    check("R3 flag set with gie low", int'(pend[0]), 1);
    check("R3 no irq with gie low", int'(irq_req[0]), 0);
    gie = 1'b1; line_mask = 2'b10; step(1);
    check("R3 no irq with mask low", int'(irq_req[0]), 0);
    line_mask = 2'b11; step(1);
    check("R3 irq with both set", int'(irq_req[0]), 1);

    // R6 clears
    ack[0] = 1'b1; step(1); ack[0] = 1'b0;
    check("R6 ack clears", int'(pend[0]), 0);
    pin[0] = 1'b1; step(3);
    pin[0] = 1'b0; step(3);
    check("R6 flag set again", int'(pend[0]), 1);
    flag_w1c[1] = 1'b1; step(1); flag_w1c[1] = 1'b0;
    check("R6 other line clear keeps flag", int'(pend[0]), 1);
    flag_w1c[0] = 1'b1; step(1); flag_w1c[0] = 1'b0;
    check("R6 w1c clears", int'(pend[0]), 0);
    pin[0] = 1'b1; step(3);

    // R7 frozen I/O clock
    wr_ctrl(8'h03); pin[0] = 1'b0; step(4); clr_all(); step(1);
    io_run = 1'b0; pin[0] = 1'b1; step(5);
    check("R7 no flag while frozen", int'(pend[0]), 0);
    pin[1] = 1'b0; step(2);
    check("R7 level path while frozen", int'(irq_req[1]), 1);
    pin[1] = 1'b1; step(2);
    io_run = 1'b1; step(1);
    check("R7 latent edge on resume", int'(pend[0]), 1);

    // R8-R11 power-down wake path
    wr_ctrl(8'h00); gie = 1'b1; line_mask = 2'b01; pin = '1; step(4);

    startup_cycles = 16'd4; powerdown = 1'b1;
    wake_run(0, k, wi);
    check("R9 wake edge count N=4", k, 9);
    check("R10 wake_irq level held", wi, 1);
    step(1);
    check("R8 level irq suppressed in powerdown", int'(irq_req[0]), 0);
    @(negedge wdt_clk); powerdown = 1'b0;
    @(posedge wdt_clk); #1;
    check("R9 wake drops after powerdown ends", int'(wake), 0);
    check("R10 wake_irq drops", int'(wake_irq), 0);
    step(1);
    check("R8 level irq resumes", int'(irq_req[0]), 1);
    sleep_exit();

    startup_cycles = 16'd0; powerdown = 1'b1;
    wake_run(0, k, wi);
    check("R9 wake edge count N=0", k, 5);
    check("R10 wake_irq N=0", wi, 1);
    sleep_exit();

    startup_cycles = 16'd4; powerdown = 1'b1;
    wake_run(5, k, wi);
    check("R10 wake with vanished level", k, 9);
    check("R10 no wake_irq for vanished level", wi, 0);
    sleep_exit();

    powerdown = 1'b1;
    wake_run(1, k, wi);
    check("R11 single sample no wake", k, 0);
    sleep_exit();

    line_mask = 2'b00; powerdown = 1'b1;
    wake_run(0, k, wi);
    check("R11 unarmed line no wake", k, 0);
    sleep_exit();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule